// File: doc/BRIEF.md
# Camera Byte-Pair Pixel Capture

This block sits in the pixel-clock domain of an image sensor that delivers each 16-bit RGB565 pixel as two consecutive bytes on an 8-bit bus. It turns that byte stream into whole pixel words for a frame-buffer writer. With each word it gives a one-cycle valid pulse, plus markers for the first and the last pixel of the frame.

Capture is gated by an enable input, which is the sensor's configuration-complete flag. The block only begins at a frame boundary: it waits for the frame sync input to fall while the enable is high. Then it pairs bytes only while the line-active input is high and frame sync is low. Column and row counters, sized by the frame-geometry parameters, find the first and the last pixel of the frame. A byte left unpaired when a line ends is dropped, so that an error cannot carry over into the next line.

Top module: `pix_pair_capture`

## Requirements
- R1: While `capture_en` is low, no pixel is emitted. When `capture_en` falls, capture stops at once and stays stopped until the next frame start, even if the enable returns high mid-frame.
- R2: Capture is armed only by a falling edge of `frm_sync` that is sampled while `capture_en` is high. If the enable rises mid-frame, nothing is emitted until the next falling edge, and the first pixel after that carries SOP.
- R3: A byte is taken only when `line_act` is high and `frm_sync` is low. Bytes presented while `line_act` is low, while `frm_sync` is high, or on the cycle in which the falling edge is sampled are ignored.
- R4: The first byte of each pair is the high byte: `px_data` = {first byte, second byte}. `px_vld` pulses for exactly one cycle per pair and is never high two cycles in a row.
- R5: The byte phase returns to "high byte next" whenever `line_act` is low. A lone byte on a line is discarded and does not shift the pairing of later lines.
- R6: `px_sop` is high, together with `px_vld`, only for the pixel at row 0, column 0 of an armed frame: exactly once per frame.
- R7: `px_eop` is high, together with `px_vld`, only for the pixel at row ROWS-1, column COLS-1: exactly once per complete frame, and never in a frame cut short by R1.
- R8: All outputs are registered. After reset all of them are 0. A pixel appears on the outputs one clock edge after its second byte is sampled.
- R9: A complete frame yields exactly COLS x ROWS valid pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Configuration-complete flag; capture allowed while high |
| frm_sync | input | 1 | Frame sync; high in frame blanking, a falling edge starts a frame |
| line_act | input | 1 | Line valid; bytes are taken while high |
| cam_byte | input | BYTE_W | Sensor data byte |
| px_data | output | 2*BYTE_W | Assembled pixel word, high byte first |
| px_vld | output | 1 | One-cycle pulse per assembled pixel |
| px_sop | output | 1 | First pixel of the frame |
| px_eop | output | 1 | Last pixel of the frame |

## Verification
Each frame uses a row- and column-dependent byte pattern whose high and low bytes differ. Pixel-by-pixel comparison therefore catches swapped byte order, an off-by-one-byte pairing and dropped pixels. Several other frames are driven as well:
- a frame with the enable low throughout;
- a frame in which the enable rises partway through;
- a frame in which the enable drops after the first row;
- a frame with a single stray byte on its own line.

Together these separate the arming rule from plain gating and show whether a lost byte pushes the phase into later lines. Junk bytes are placed on the bus during line gaps and during sync. A single hand-timed pixel pins down the output latency. Two back-to-back frames show that SOP and EOP recur exactly once per frame.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic {PH_HI = 1'b0, PH_LO = 1'b1} phase_t;

  // true when (col,row) is the origin of the frame
  function automatic logic pos_origin(input int unsigned col, input int unsigned row);
    return (col == 0) && (row == 0);
  endfunction

  // true when (col,row) is the final pixel of a cols x rows frame
  function automatic logic pos_final(input int unsigned col, input int unsigned row,
                                     input int unsigned cols, input int unsigned rows);
    return (col == cols - 1) && (row == rows - 1);
  endfunction

  // true when col is the last column of a line
  function automatic logic pos_line_end(input int unsigned col, input int unsigned cols);
    return col == cols - 1;
  endfunction

endpackage

// File: rtl/cap_frame_gate.sv
module cap_frame_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_en,
  input  logic frm_sync,
  input  logic line_act,
  output logic frame_start,
  output logic take
);
  logic sync_q;
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sync_q <= frm_sync;
      if (!capture_en)
        armed_q <= 1'b0;
      else if (frame_start)
        armed_q <= 1'b1;
    end
  end

  assign frame_start = sync_q & ~frm_sync;
  assign take        = armed_q & capture_en & line_act & ~frm_sync & ~frame_start;

endmodule

// File: rtl/cap_byte_pair.sv
module cap_byte_pair #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [BYTE_W-1:0]     byte_in,
  output logic                  pair_done,
  output logic [2*BYTE_W-1:0]   word
);
  import cap_pkg::*;

  localparam int WORD_W = 2 * BYTE_W;

  phase_t            phase_q;
  logic [BYTE_W-1:0] hi_q;

  function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HI;
      hi_q    <= '0;
    end else if (!take) begin
      phase_q <= PH_HI;
    end else if (phase_q == PH_HI) begin
      hi_q    <= byte_in;
      phase_q <= PH_LO;
    end else begin
      phase_q <= PH_HI;
    end
  end

  assign pair_done = take && (phase_q == PH_LO);
  assign word      = join_bytes(hi_q, byte_in);

endmodule

// File: rtl/cap_pos_track.sv
module cap_pos_track #(
  parameter int COLS = 1280,
  parameter int ROWS = 720
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic pair_done,
  output logic at_first,
  output logic at_last
);
  import cap_pkg::*;

  localparam int COL_W = $clog2(COLS + 1);
  localparam int ROW_W = $clog2(ROWS + 1);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (frame_start) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pair_done) begin
      if (pos_line_end(32'(col_q), COLS)) begin
        col_q <= '0;
        if (row_q == ROW_W'(ROWS - 1))
          row_q <= '0;
        else
          row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign at_first = pos_origin(32'(col_q), 32'(row_q));
  assign at_last  = pos_final(32'(col_q), 32'(row_q), COLS, ROWS);

endmodule

// File: rtl/pix_pair_capture.sv
module pix_pair_capture #(
  parameter int BYTE_W = 8,
  parameter int COLS   = 1280,
  parameter int ROWS   = 720
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture_en,
  input  logic                frm_sync,
  input  logic                line_act,
  input  logic [BYTE_W-1:0]   cam_byte,
  output logic [2*BYTE_W-1:0] px_data,
  output logic                px_vld,
  output logic                px_sop,
  output logic                px_eop
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              frame_start;
  logic              take;
  logic              pair_done;
  logic              at_first;
  logic              at_last;
  logic [WORD_W-1:0] word;

  cap_frame_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .frm_sync   (frm_sync),
    .line_act   (line_act),
    .frame_start(frame_start),
    .take       (take)
  );

  cap_byte_pair #(.BYTE_W(BYTE_W)) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .byte_in  (cam_byte),
    .pair_done(pair_done),
    .word     (word)
  );

  cap_pos_track #(.COLS(COLS), .ROWS(ROWS)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .pair_done  (pair_done),
    .at_first   (at_first),
    .at_last    (at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_data <= '0;
      px_vld  <= 1'b0;
      px_sop  <= 1'b0;
      px_eop  <= 1'b0;
    end else begin
      px_vld <= pair_done;
      px_sop <= pair_done & at_first;
      px_eop <= pair_done & at_last;
      if (pair_done)
        px_data <= word;
    end
  end

endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                capture_en,
  input logic                frm_sync,
  input logic                line_act,
  input logic [BYTE_W-1:0]   cam_byte,
  input logic                pair_done,
  input logic [2*BYTE_W-1:0] px_data,
  input logic                px_vld,
  input logic                px_sop,
  input logic                px_eop
);
  assert_vld_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld |-> $past(capture_en));

  assert_vld_needs_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld |-> ($past(line_act) && $past(line_act, 2) && !$past(frm_sync)));

  assert_word_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld |-> (px_data == {$past(cam_byte, 2), $past(cam_byte)}));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld |=> !px_vld);

  assert_sop_marks_pixel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    px_sop |-> px_vld);

  assert_eop_marks_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    px_eop |-> px_vld);

  assert_pair_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> px_vld);

endmodule

bind pix_pair_capture cap_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .capture_en(capture_en),
  .frm_sync  (frm_sync),
  .line_act  (line_act),
  .cam_byte  (cam_byte),
  .pair_done (pair_done),
  .px_data   (px_data),
  .px_vld    (px_vld),
  .px_sop    (px_sop),
  .px_eop    (px_eop)
);

// File: tb/pix_pair_capture_test.sv
`timescale 1ns/1ps
module pix_pair_capture_test;
  localparam int T_COLS = 4;
  localparam int T_ROWS = 3;
  localparam int T_PIX  = T_COLS * T_ROWS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        capture_en = 1'b0;
  logic        frm_sync = 1'b1;
  logic        line_act = 1'b0;
  logic [7:0]  cam_byte = 8'h00;
  logic [15:0] px_data;
  logic        px_vld, px_sop, px_eop;

  int n_chk = 0;
  int n_fail = 0;

  // monitor state
  int n_pix = 0, n_sop = 0, n_eop = 0, val_err = 0;
  int sop_idx = -1, eop_idx = -1;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  pix_pair_capture #(.BYTE_W(8), .COLS(T_COLS), .ROWS(T_ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .frm_sync(frm_sync),
    .line_act(line_act), .cam_byte(cam_byte), .px_data(px_data),
    .px_vld(px_vld), .px_sop(px_sop), .px_eop(px_eop));

  always @(negedge clk) begin
    if (rst_n && px_vld) begin
      if (px_sop) begin n_sop++; sop_idx = n_pix; end
      if (px_eop) begin n_eop++; eop_idx = n_pix; end
      if (exp_q.size() == 0) val_err++;
      else if (exp_q.pop_front() != px_data) val_err++;
      n_pix++;
    end
  end

  function automatic logic [15:0] pix_val(input int seed, input int r, input int c);
    return {4'(seed), 4'(r), 8'(c * 37 + r * 5 + 1)};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_pix = 0; n_sop = 0; n_eop = 0; val_err = 0; sop_idx = -1; eop_idx = -1;
    exp_q.delete();
  endtask

  task automatic check_frame(input string tag, input int e_pix, input int e_sop, input int e_eop,
                             input int e_sop_idx, input int e_eop_idx);
    check(n_pix == e_pix, {tag, " R9 pixel count"}, n_pix, e_pix);
    check(n_sop == e_sop, {tag, " R6 sop count"}, n_sop, e_sop);
    check(n_eop == e_eop, {tag, " R7 eop count"}, n_eop, e_eop);
    if (e_sop > 0) check(sop_idx == e_sop_idx, {tag, " R6 sop position"}, sop_idx, e_sop_idx);
    if (e_eop > 0) check(eop_idx == e_eop_idx, {tag, " R7 eop position"}, eop_idx, e_eop_idx);
    check(val_err == 0 && exp_q.size() == 0, {tag, " R4 pixel values"}, val_err, 0);
  endtask

  // drives one frame; returns the number of pixels the bench expects captured
  task automatic send_frame(input int seed, input bit en_start, input bit [T_ROWS-1:0] en_mask,
                            input int stray_row, output int n_exp);
    bit alive;
    logic [15:0] w;
    n_exp = 0;
    @(negedge clk);
    frm_sync = 1'b1; line_act = 1'b0; capture_en = en_start;
    repeat (2) @(negedge clk);
    line_act = 1'b1; cam_byte = 8'hF0; @(negedge clk);   // R3 junk during sync
    cam_byte = 8'h0F; @(negedge clk);
    line_act = 1'b0; @(negedge clk);
    frm_sync = 1'b0; cam_byte = 8'h77;
    @(negedge clk);
    alive = en_start;
    for (int r = 0; r < T_ROWS; r++) begin
      capture_en = en_mask[r];
      alive = alive && en_mask[r];
      cam_byte = 8'hA5;                                   // R3 junk with line low
      repeat (2) @(negedge clk);
      if (r == stray_row) begin                           // R5 lone byte
        line_act = 1'b1; cam_byte = 8'hEE; @(negedge clk);
        line_act = 1'b0; cam_byte = 8'h11; @(negedge clk);
      end
      for (int c = 0; c < T_COLS; c++) begin
        w = pix_val(seed, r, c);
        if (alive) begin exp_q.push_back(w); n_exp++; end
        line_act = 1'b1; cam_byte = w[15:8]; @(negedge clk);
        cam_byte = w[7:0]; @(negedge clk);
      end
      line_act = 1'b0;
    end
    cam_byte = 8'h5A;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(px_vld == 0 && px_sop == 0 && px_eop == 0 && px_data == 0, "R8 reset outputs",
          int'(px_vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_latency();
    clear_mon();
    capture_en = 1'b1; frm_sync = 1'b1; line_act = 1'b0;
    repeat (2) @(negedge clk);
    frm_sync = 1'b0; @(negedge clk);
    line_act = 1'b1; cam_byte = 8'hA5; @(negedge clk);
    cam_byte = 8'h3C; @(negedge clk);
    line_act = 1'b0;
    check(px_vld == 1'b1, "R8 pixel one edge after second byte", int'(px_vld), 1);
    check(px_data == 16'hA53C, "R4 high byte first", int'(px_data), 16'hA53C);
    check(px_sop == 1'b1, "R6 sop on first pixel", int'(px_sop), 1);
    @(negedge clk);
    check(px_vld == 1'b0, "R4 single-cycle valid", int'(px_vld), 0);
    repeat (3) @(negedge clk);
    clear_mon();
  endtask

  task automatic t_normal();
    int ne;
    clear_mon();
    send_frame(1, 1'b1, '1, -1, ne);
    check_frame("normal", T_PIX, 1, 1, 0, T_PIX - 1);
    check(ne == T_PIX, "R9 bench expectation", ne, T_PIX);
  endtask

  task automatic t_disabled();
    int ne;
    clear_mon();
    send_frame(2, 1'b0, '0, -1, ne);
    check(n_pix == 0, "R1 no pixel while enable low", n_pix, 0);
    check(n_sop == 0 && n_eop == 0, "R1 no markers while enable low", n_sop + n_eop, 0);
  endtask

  task automatic t_midframe_enable();
    int ne;
    clear_mon();
    send_frame(3, 1'b0, 3'b110, -1, ne);
    check(n_pix == 0, "R2 no pixel after mid-frame enable", n_pix, 0);
    clear_mon();
    send_frame(4, 1'b1, '1, -1, ne);
    check_frame("R2 next frame", T_PIX, 1, 1, 0, T_PIX - 1);
  endtask

  task automatic t_stray();
    int ne;
    clear_mon();
    send_frame(5, 1'b1, '1, 1, ne);
    check_frame("R5 stray byte", T_PIX, 1, 1, 0, T_PIX - 1);
  endtask

  task automatic t_en_drop();
    int ne;
    clear_mon();
    send_frame(6, 1'b1, 3'b101, -1, ne);
    check(n_pix == T_COLS, "R1 capture stops on enable drop", n_pix, T_COLS);
    check(n_eop == 0, "R7 no eop in cut frame", n_eop, 0);
    check(n_sop == 1, "R6 sop in cut frame", n_sop, 1);
    check(val_err == 0 && exp_q.size() == 0, "R1 values before drop", val_err, 0);
  endtask

  task automatic t_back_to_back();
    int ne;
    clear_mon();
    send_frame(7, 1'b1, '1, -1, ne);
    send_frame(8, 1'b1, '1, -1, ne);
    check_frame("R9 two frames", 2 * T_PIX, 2, 2, T_PIX, 2 * T_PIX - 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_latency();
    t_normal();
    t_disabled();
    t_midframe_enable();
    t_stray();
    t_en_drop();
    t_back_to_back();
    finish_run();
  end

endmodule